// File: doc/BRIEF.md
# Direction-Bit Phase Reconstruction

This unit sits at the end of a hybrid vectoring rotation pipeline. Its input is the record of which way each stage turned the vector. Its output is the phase angle. It never accumulates angles stage by stage.

The two leading stages (i=2 and i=3) use true arctangent angles. Their contribution comes from a two-entry table, halved by symmetry, followed by an add/subtract step. The twelve trailing stages (i=4..15) use power-of-two angles. Their contribution is the recorded direction word rotated by one place, plus a fixed correction when the first of those stages turned negatively.

The result is registered once. A valid flag travels alongside it.

Top module: `dirbit_angle`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `out_valid` is 0 and `angle` is 0.
- R2: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high.
- R3: When `sf_dir[11]` (stage i=4) is 1, the trailing-stage part of `angle` in units of 2^-16 is the word {sf_dir[10:0], sf_dir[11]} shifted left by one.
- R4: When `sf_dir[11]` is 0, the trailing-stage part is that same rotated and shifted word minus 8190, i.e. minus 2^-3 and plus 2^-15.
- R5: The table entry is 24205 (atan 2^-2 + atan 2^-3) when `cls_dir[1]` equals `cls_dir[0]`, and 7905 (atan 2^-2 − atan 2^-3) when they differ. It is added when `cls_dir[1]` (stage i=2) is 1.
- R6: When `cls_dir[1]` is 0, the table entry is subtracted, so an all-negative leading pair gives a negative angle.
- R7: `angle` is two's complement with 16 fractional bits, in radians. It is within 1 LSB of Σσ_i·atan(2^-i) over i=2,3 plus Σσ_i·2^-i over i=4..15, with σ=+1 for a 1 bit and −1 for a 0 bit.
- R8: `angle` keeps its value in any cycle that follows a cycle with `in_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Direction bits present this cycle |
| cls_dir | input | 2 | Leading-stage directions; bit 1 is stage i=2, bit 0 is stage i=3; 1 means positive |
| sf_dir | input | 12 | Trailing-stage directions; bit 11 is stage i=4, bit 0 is stage i=15 |
| out_valid | output | 1 | `angle` holds a new result |
| angle | output | 16 | Signed phase, 2^-16 rad per LSB |

## Verification
The subtracting table path and the negative-start correction can both act on the same sample. When they do, two negative terms add together and the result sits at the most negative end of the range. The bench sweeps all 16384 direction patterns, so every pairing of table sign, table entry and trailing-stage start sign occurs. Each result is compared exactly against integer arithmetic taken from the requirements, and also against a real-valued sum of signed angles within 1 LSB. Idle gaps are spread through the stream to check the hold behaviour between results.

// File: rtl/dirbit_angle.sv
module dirbit_angle #(
  parameter int SF_N     = 12,
  parameter int ANGLE_W  = 16,
  parameter int ROM_SUM  = 24205,
  parameter int ROM_DIFF = 7905
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [1:0]         cls_dir,
  input  logic [SF_N-1:0]    sf_dir,
  output logic               out_valid,
  output logic [ANGLE_W-1:0] angle
);
  localparam int W       = ANGLE_W + 2;
  localparam int NEG_FIX = (1 << (ANGLE_W - 3)) - (1 << (ANGLE_W - 15));

  logic [SF_N-1:0]     rot;
  logic signed [W-1:0] sf_val, rom_val, cls_val, total;
  logic                rom_sel;

  assign rot     = {sf_dir[SF_N-2:0], sf_dir[SF_N-1]};
  assign sf_val  = signed'(W'({rot, 1'b0})) - (sf_dir[SF_N-1] ? W'(0) : W'(NEG_FIX));
  assign rom_sel = ~(cls_dir[1] ^ cls_dir[0]);
  assign rom_val = rom_sel ? W'(ROM_SUM) : W'(ROM_DIFF);
  assign cls_val = cls_dir[1] ? rom_val : -rom_val;
  assign total   = cls_val + sf_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      angle     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) angle <= total[ANGLE_W-1:0];
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    out_valid == $past(in_valid));

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(in_valid) |-> $stable(angle));

  a_r5_both_pos: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid && cls_dir == 2'b11) |-> !angle[ANGLE_W-1] && angle != '0);

  a_r6_both_neg: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid && cls_dir == 2'b00) |-> angle[ANGLE_W-1]);

  a_r7_range: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($signed(angle) <= ROM_SUM + NEG_FIX) && ($signed(angle) >= -(ROM_SUM + NEG_FIX)));
endmodule

// File: tb/sim_dirbit_angle.sv
module sim_dirbit_angle;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst = 1, in_valid = 0;
  logic [1:0]  cls_dir = 0;
  logic [11:0] sf_dir = 0;
  logic        out_valid;
  logic [15:0] angle;

  int tests = 0, fails = 0;
  int   exp_q[$];
  real  ref_q[$];
  bit   neg_q[$];
  logic vld_d = 0;
  logic [15:0] last_angle = 0;
  bit   have_last = 0, done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dirbit_angle u0 (.clk(clk), .rst(rst), .in_valid(in_valid), .cls_dir(cls_dir),
                   .sf_dir(sf_dir), .out_valid(out_valid), .angle(angle));

  task automatic check(input bit ok, input string req, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic drive(input logic [1:0] c, input logic [11:0] s);
    int rot, sfi, tab, ei;
    real r;
    @(negedge clk);
    in_valid = 1; cls_dir = c; sf_dir = s;
    rot = {s[10:0], s[11]};
    sfi = (rot << 1) - (s[11] ? 0 : 8190);
    tab = (c[1] == c[0]) ? 24205 : 7905;
    ei  = (c[1] ? tab : -tab) + sfi;
    r = (c[1] ? 1.0 : -1.0) * $atan(0.25) + (c[0] ? 1.0 : -1.0) * $atan(0.125);
    for (int i = 4; i <= 15; i++)
      r += (s[15-i] ? 1.0 : -1.0) * (2.0 ** (-i));
    exp_q.push_back(ei);
    ref_q.push_back(r * 65536.0);
    neg_q.push_back(!s[11]);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 0;
  endtask

  always @(posedge clk) vld_d <= rst ? 1'b0 : in_valid;

  always @(negedge clk) if (!rst && !done) begin
    check(out_valid == vld_d, "R2", out_valid, vld_d);
    if (out_valid) begin
      if (exp_q.size() == 0) check(0, "R2", 1, 0);
      else begin
        int ei; real r; bit n; real d;
        ei = exp_q.pop_front(); r = ref_q.pop_front(); n = neg_q.pop_front();
        check($signed(angle) == ei, n ? "R4/R5/R6" : "R3/R5/R6", $signed(angle), ei);
        d = $itor($signed(angle)) - r;
        check(d <= 1.0 && d >= -1.0, "R7", $signed(angle), $rtoi(r));
      end
    end else if (have_last) begin
      check(angle == last_angle, "R8", angle, last_angle);
    end
    last_angle = angle; have_last = 1;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; tests++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 0, "R1", out_valid, 0);
    check(angle == 0, "R1", angle, 0);
    rst = 0;
    @(negedge clk);
    check(out_valid == 0 && angle == 0, "R1", angle, 0);
    // R6 and R4 together: most negative corner
    drive(2'b00, 12'h000);
    // R5 and R3 together: most positive corner
    drive(2'b11, 12'hFFF);
    idle(); idle();
    for (int p = 0; p < 16384; p++) begin
      drive(p[13:12], p[11:0]);
      if (p % 7 == 3) idle();
    end
    idle(); idle(); idle();
    done = 1;
    check(exp_q.size() == 0, "R2", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule